// File: doc/BRIEF.md
# Self-Calibrating Serial Wake Address Matcher

This block sits behind the data slicer of a low-power wake-up radio. A strobe from the preamble logic arms it. It first watches a fixed calibration character on the serial line. From the edges of that character it measures how many clock cycles one bit lasts in this particular packet. It then receives the node address as a run of asynchronous byte frames, using the bit period it just measured. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit.

Each received byte is compared with the matching byte of a stored node address. When every byte agrees, the block raises a one-cycle wake interrupt for the main processor. In every other case it ends with a one-cycle mismatch indication. Because the timing is measured again in every packet, a transmitter whose bit rate drifts, or a slicer that stretches pulses, is tolerated without any fixed rate setting.

Top module: `wkaddr_correlator`

## Requirements
- R1: After reset, and while no start strobe has been seen, `wake_irq_o`, `done_o` and `mismatch_o` are low, and serial activity on `rxd_i` produces no `done_o`.
- R2: After a start strobe, the calibration character is 0x55 framed as one asynchronous frame: ten alternating line levels, starting low and ending on the high stop bit. The block counts the clock cycles from the first falling edge to the tenth edge, which spans nine bit times, and takes the bit period as that count divided by nine, rounded to the nearest cycle. Bit periods of at least 4 cycles are supported.
- R3: The first address frame begins at the first low level after the calibration character. The start bit is confirmed at half a bit period, and each data bit and the stop bit are sampled one bit period apart, at mid-bit. Data arrives least significant bit first.
- R4: The number of address frames is `frames_m1_i + 1`, so the values 0 to 7 select 1 to 8 frames.
- R5: Frame i, counted from 0, is compared with `node_addr_i[8*i+7 : 8*i]`. If all frames match, `wake_irq_o` and `done_o` pulse together for one cycle and `mismatch_o` stays low.
- R6: If any data byte differs, the block still receives every frame. It then pulses `done_o` and `mismatch_o` together after the last stop bit, with no `wake_irq_o`, and no `done_o` appears before the last frame.
- R7: A stop bit sampled low ends the sequence at once: `done_o` and `mismatch_o` pulse, no `wake_irq_o` is raised, and no further frames are awaited.
- R8: A low level that reads high again at the half-period start-bit check is treated as noise and ignored, and the block keeps waiting for a real start bit.
- R9: A start strobe at any time aborts the packet in progress and restarts calibration. No `done_o` follows in the next cycle.
- R10: Each packet produces exactly one `done_o` pulse, one cycle long. `wake_irq_o` and `mismatch_o` are only ever high together with `done_o`, and exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe that arms calibration |
| rxd_i | input | 1 | Sliced serial line, idle high |
| node_addr_i | input | 64 | Stored address, byte i holds frame i |
| frames_m1_i | input | 3 | Number of address frames minus one |
| wake_irq_o | output | 1 | One-cycle pulse on a full address match |
| done_o | output | 1 | One-cycle pulse when the packet is finished |
| mismatch_o | output | 1 | One-cycle pulse with done on a mismatch or framing error |

## Verification
The bench uses calibration bits of unequal length whose average is not a whole number of cycles. A design that truncates the period instead of rounding it drifts across the frame and reads wrong bits or a false framing error. A one-cycle low blip ahead of the first frame must be rejected; a design without the half-period check locks onto it and misreads every byte. Mismatches are placed in both the first and the last byte. This catches a design that stops early, that drops the mismatch from an earlier byte, or that compares the wrong address byte. The bench also covers the one-frame and eight-frame counts, a bad stop bit in the middle of a packet, and a restart while calibration is under way.

// File: rtl/wkaddr_pkg.sv
package wkaddr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CAL,
    ST_RECV
  } ctl_st_e;

  // calibration character: ten alternating levels, nine bit times between first and last edge
  localparam int CAL_EDGES = 10;
  localparam int CAL_BITS  = CAL_EDGES - 1;

  // rounded division of the measured span by the number of bit times it covers
  function automatic int unsigned bit_period(input int unsigned span);
    return (span + CAL_BITS / 2) / CAL_BITS;
  endfunction

endpackage

// File: rtl/wkaddr_sync.sv
module wkaddr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] sr;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      prev <= 1'b1;
    end else begin
      sr   <= {sr[STAGES-2:0], din};
      prev <= sr[STAGES-1];
    end
  end

  assign dout = sr[STAGES-1];
  assign fell = prev & ~dout;
  assign rose = ~prev & dout;
endmodule

// File: rtl/wkaddr_baud.sv
module wkaddr_baud
  import wkaddr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fell,
  input  logic             rose,
  output logic [CNT_W-1:0] period,
  output logic             cal_done
);
  logic             armed;
  logic [3:0]       edges;
  logic [CNT_W-1:0] span;
  logic             any_edge;

  assign any_edge = fell | rose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      edges    <= '0;
      span     <= '0;
      cal_done <= 1'b0;
      period   <= '0;
    end else if (!en) begin
      armed    <= 1'b0;
      edges    <= '0;
      span     <= '0;
      cal_done <= 1'b0;
    end else begin
      cal_done <= 1'b0;
      if (!armed) begin
        if (fell) begin
          armed <= 1'b1;
          edges <= 4'd1;
          span  <= '0;
        end
      end else begin
        span <= span + 1'b1;
        if (any_edge) begin
          edges <= edges + 1'b1;
          if (edges == 4'(CAL_EDGES - 1)) begin
            cal_done <= 1'b1;
            armed    <= 1'b0;
            period   <= CNT_W'(bit_period(32'(span) + 32'd1));
          end
        end
      end
    end
  end

  // the closing edge of the framed calibration character must be a rising one
  AST_CAL_ENDS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> $past(rose)); // R2
endmodule

// File: rtl/wkaddr_frame.sv
module wkaddr_frame #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             line,
  input  logic [CNT_W-1:0] period,
  output logic             byte_vld,
  output logic [7:0]       byte_out,
  output logic             stop_bad
);
  logic             busy;
  logic [3:0]       bidx;
  logic [CNT_W-1:0] tick;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] target;
  logic             sample;

  assign target   = (bidx == 4'd0) ? (period >> 1) : period;
  assign sample   = busy && (tick == target - 1'b1);
  assign byte_out = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bidx     <= '0;
      tick     <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      stop_bad <= 1'b0;
    end else if (!en) begin
      busy     <= 1'b0;
      bidx     <= '0;
      tick     <= '0;
      byte_vld <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      if (!busy) begin
        if (!line) begin
          busy <= 1'b1;
          bidx <= '0;
          tick <= '0;
        end
      end else if (sample) begin
        tick <= '0;
        if (bidx == 4'd0) begin
          if (line) busy <= 1'b0;
          else      bidx <= 4'd1;
        end else if (bidx == 4'd9) begin
          byte_vld <= 1'b1;
          stop_bad <= ~line;
          busy     <= 1'b0;
        end else begin
          shreg <= {line, shreg[7:1]};
          bidx  <= bidx + 1'b1;
        end
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  AST_BYTE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld); // R3
  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !byte_vld); // R1
endmodule

// File: rtl/wkaddr_correlator.sv
module wkaddr_correlator
  import wkaddr_pkg::*;
#(
  parameter  int MAX_FRAMES  = 8,
  parameter  int CNT_W       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = 8 * MAX_FRAMES,
  localparam int FIDX_W      = $clog2(MAX_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rxd_i,
  input  logic [ADDR_W-1:0] node_addr_i,
  input  logic [FIDX_W-1:0] frames_m1_i,
  output logic              wake_irq_o,
  output logic              done_o,
  output logic              mismatch_o
);
  ctl_st_e           state;
  logic [FIDX_W-1:0] fidx;
  logic              miss;

  logic              line, fell, rose;
  logic [CNT_W-1:0]  period;
  logic              cal_done;
  logic              rx_vld, rx_stop_bad;
  logic [7:0]        rx_byte;
  logic [7:0]        want;
  logic              byte_ne, last_frame;

  wkaddr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(line), .fell(fell), .rose(rose)
  );

  wkaddr_baud #(.CNT_W(CNT_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en((state == ST_CAL) && !start_i),
    .fell(fell), .rose(rose), .period(period), .cal_done(cal_done)
  );

  wkaddr_frame #(.CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(state == ST_RECV), .line(line), .period(period),
    .byte_vld(rx_vld), .byte_out(rx_byte), .stop_bad(rx_stop_bad)
  );

  assign want       = node_addr_i[{fidx, 3'b000} +: 8];
  assign byte_ne    = (rx_byte != want);
  assign last_frame = (fidx == frames_m1_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fidx       <= '0;
      miss       <= 1'b0;
      wake_irq_o <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
    end else begin
      wake_irq_o <= 1'b0;
      done_o     <= 1'b0;
      mismatch_o <= 1'b0;
      if (start_i) begin
        state <= ST_CAL;
        fidx  <= '0;
        miss  <= 1'b0;
      end else begin
        case (state)
          ST_CAL: if (cal_done) state <= ST_RECV;
          ST_RECV: begin
            if (rx_vld) begin
              if (rx_stop_bad) begin
                done_o     <= 1'b1;
                mismatch_o <= 1'b1;
                state      <= ST_IDLE;
              end else if (last_frame) begin
                done_o     <= 1'b1;
                wake_irq_o <= ~(miss | byte_ne);
                mismatch_o <= miss | byte_ne;
                state      <= ST_IDLE;
              end else begin
                fidx <= fidx + 1'b1;
                miss <= miss | byte_ne;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($countones({wake_irq_o, mismatch_o}) == 1)); // R10
  AST_VERDICT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq_o || mismatch_o) |-> done_o); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_IRQ_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq_o |-> $past(rx_vld)); // R5
  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV) |-> (fidx <= frames_m1_i)); // R4
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o); // R9
endmodule

// File: tb/wkaddr_correlator_bench.sv
module wkaddr_correlator_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rxd_i = 1'b1;
  logic [63:0] node_addr_i = '0;
  logic [2:0]  frames_m1_i = '0;
  logic        wake_irq_o, done_o, mismatch_o;

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;
  bit got_irq, got_mm;

  always #(CLK_NS / 2) clk = ~clk;

  wkaddr_correlator u_wkaddr_correlator (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rxd_i(rxd_i),
    .node_addr_i(node_addr_i), .frames_m1_i(frames_m1_i),
    .wake_irq_o(wake_irq_o), .done_o(done_o), .mismatch_o(mismatch_o)
  );

  always @(negedge clk) begin
    if (done_o) begin
      n_done  = n_done + 1;
      got_irq = wake_irq_o;
      got_mm  = mismatch_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int n);
    rxd_i = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // ten alternating levels; even-indexed bits last ta cycles, odd-indexed tb
  task automatic send_cal(input int ta, input int tb, input int nbits);
    for (int i = 0; i < nbits; i++) hold(i[0], i[0] ? tb : ta);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit stp, input int t);
    hold(1'b0, t);
    for (int i = 0; i < 8; i++) hold(b[i], t);
    hold(stp, t);
  endtask

  task automatic packet(input string req, input logic [63:0] a, input int nfr,
                        input logic [7:0] d [8], input int t, input int ca, input int cb,
                        input int bad_at, input bit glitch);
    bit match = 1'b1;
    int pre = 0;
    for (int i = 0; i < nfr; i++) if (d[i] != a[8*i +: 8]) match = 1'b0;
    if (bad_at >= 0) match = 1'b0;
    node_addr_i = a;
    frames_m1_i = 3'(nfr - 1);
    pulse_start();
    n_done = 0;
    hold(1'b1, 3);
    send_cal(ca, cb, 9);
    hold(1'b1, 2 * t);
    if (glitch) begin
      hold(1'b0, 1);
      hold(1'b1, t);
    end
    for (int i = 0; i < nfr; i++) begin
      pre = n_done;
      send_frame(d[i], i != bad_at, t);
      if (i == bad_at) break;
      hold(1'b1, 3);
    end
    hold(1'b1, 2 * t);
    chk(n_done == 1, {req, " single done per packet R10"}, n_done, 1);
    chk(got_irq == match, {req, " wake irq"}, got_irq, match);
    chk(got_mm == !match, {req, " mismatch"}, got_mm, !match);
    if (bad_at < 0) chk(pre == 0, {req, " no done before last frame R6"}, pre, 0);
  endtask

  initial begin
    logic [7:0] d [8];
    repeat (4) @(negedge clk);
    chk({wake_irq_o, done_o, mismatch_o} == 3'b000, "R1 reset outputs", {wake_irq_o, done_o, mismatch_o}, 0);
    rst_n = 1'b1;
    hold(1'b1, 5);
    chk({wake_irq_o, done_o, mismatch_o} == 3'b000, "R1 idle outputs", {wake_irq_o, done_o, mismatch_o}, 0);

    // R1: serial traffic without a start strobe is ignored
    n_done = 0;
    send_cal(8, 8, 9);
    hold(1'b1, 16);
    send_frame(8'h3C, 1'b1, 8);
    hold(1'b1, 20);
    chk(n_done == 0, "R1 no done without start", n_done, 0);

    // R2 R3 R5: two frames, exact bit rate 8
    d = '{8'hC3, 8'hA5, 0, 0, 0, 0, 0, 0};
    packet("R5 match 2 frames", 64'h0000_0000_0000_A5C3, 2, d, 8, 8, 8, -1, 1'b0);

    // R4: eight frames at rate 13
    d = '{8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A, 8'hA5, 8'h7E, 8'h99};
    packet("R4 eight frames", 64'h997E_A55A_00FF_8001, 8, d, 13, 13, 13, -1, 1'b0);

    // R6: mismatch in the first byte of four
    d = '{8'h12, 8'h34, 8'h56, 8'h78, 0, 0, 0, 0};
    packet("R6 first byte wrong", 64'h0000_0000_7856_3413, 4, d, 20, 20, 20, -1, 1'b0);
    // R6: mismatch only in the last byte
    packet("R6 last byte wrong", 64'h0000_0000_7956_3412, 4, d, 9, 9, 9, -1, 1'b0);

    // R7: bad stop bit on frame 1 of 4
    packet("R7 framing error", 64'h0000_0000_7856_3412, 4, d, 10, 10, 10, 1, 1'b0);

    // R8: short low blip before the first start bit
    d = '{8'hE7, 8'h18, 0, 0, 0, 0, 0, 0};
    packet("R8 glitch rejected", 64'h0000_0000_0000_18E7, 2, d, 16, 16, 16, -1, 1'b1);

    // R2: uneven calibration bits, 95 cycles over nine bits rounds to 11
    d = '{8'h2B, 8'h61, 8'h0F, 8'h44, 0, 0, 0, 0};
    packet("R2 rounded period", 64'h0000_0000_440F_612B, 4, d, 11, 11, 10, -1, 1'b0);

    // R4: single frame, match and mismatch
    d = '{8'h6D, 0, 0, 0, 0, 0, 0, 0};
    packet("R4 one frame match", 64'hFFFF_FFFF_FFFF_FF6D, 1, d, 9, 9, 9, -1, 1'b0);
    packet("R4 one frame wrong", 64'h0000_0000_0000_006C, 1, d, 9, 9, 9, -1, 1'b0);

    // R9: restart in the middle of calibration at a different rate
    pulse_start();
    hold(1'b1, 3);
    send_cal(25, 25, 5);
    d = '{8'hB4, 8'h4B, 0, 0, 0, 0, 0, 0};
    packet("R9 restart", 64'h0000_0000_0000_4BB4, 2, d, 12, 12, 12, -1, 1'b0);

    chk({wake_irq_o, done_o, mismatch_o} == 3'b000, "R10 outputs low after packet", {wake_irq_o, done_o, mismatch_o}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule